// File: doc/BRIEF.md
# Machine-Check Error Bank Controller

This block keeps the hardware error-reporting state of one processor core: a parameterised set of reporting banks plus a global capability word, a global control word and a global status word. Error sources hand it an injection (target bank, bank status word, global status word, faulting address, extra information word) in a single strobed cycle. The controller decides whether the event is logged, logged with the overflow mark, folded into an existing record, dropped, or escalated into a system reset request. A logged uncorrected error also raises a one-cycle request for the machine-check exception.

Software reaches every register through a simple address/strobe port with combinational read data. The two control-type registers act as switches: a write changes them only when the value is all zeros or all ones. The record registers take any value. An injection and a register write may arrive together; the injection wins for the bank it targets.

Top module: `mce_bank_ctrl`

## Requirements
- R1: After reset every bank control word and the global control word read all ones, every bank status, address and misc word and the global status word read zero, the capability word reads 0x10A (bank count 10 in bits 7:0, bit 8 set for a present global control word), and neither request output is high.
- R2: Address map: capability at 0x010, global status at 0x011, global control at 0x012, and bank b at 0x400+4b (+0 control, +1 status, +2 address, +3 misc). Any other address reads zero and a write to it changes nothing.
- R3: A write to the global control word or to a bank control word takes effect only when the data is all zeros or all ones; any other value leaves the register unchanged.
- R4: Bank status, address and misc words and the global status word accept any written value and read it back.
- R5: An injection whose bank number is 10 or more, or whose status bit 63 (valid) is clear, changes no register and raises no request.
- R6: An injection with status bit 61 (uncorrected) set is dropped, changing nothing and raising nothing, when the global control word is not all ones or the target bank control word is not all ones.
- R7: An uncorrected injection that passes R6 while global status bit 2 (in progress) is set or the enable input os_mce_en is low logs nothing and raises reset_req for exactly the cycle after the injection.
- R8: An accepted uncorrected injection writes the injected status (with bit 62, overflow, added if the bank already held a valid record), address, misc and global status, and raises mce_req for exactly the cycle after the injection.
- R9: A corrected injection (bit 61 clear) into a bank that is empty or holds a corrected record replaces status, address and misc, adding bit 62 if the bank was valid, and raises no request.
- R10: A corrected injection into a bank holding a valid uncorrected record only sets bit 62 of the existing status; address and misc stay unchanged.
- R11: In a cycle with both an injection and a register write aimed at the same bank, the write is discarded; a write to a different bank in that cycle takes effect.
- R12: mce_req and reset_req are never high together and each lasts one cycle per injection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| os_mce_en | input | 1 | Operating system has enabled machine-check exceptions |
| reg_addr | input | 12 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, same cycle |
| inj_valid | input | 1 | Injection strobe, processed in this cycle |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | 64 | Bank status word of the event |
| inj_gstatus | input | 64 | Global status word of the event |
| inj_addr | input | 64 | Faulting address |
| inj_misc | input | 64 | Extra information word |
| mce_req | output | 1 | One-cycle exception request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that injection fields and register port inputs are stable around the clock edge and that reset is released away from the edge; the bench drives every input on the falling edge and samples half a phase later. The request-origin properties take for granted that a request can only follow a strobed uncorrected injection, so the stimulus never holds inj_valid for more than one cycle and always clears it before the next event. Back-to-back uncorrected injections are kept apart by at least two idle cycles so each pulse is observed in isolation.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int WORD_W = 64;
  typedef logic [WORD_W-1:0] word_t;

  localparam int ST_VALID  = 63;
  localparam int ST_OVER   = 62;
  localparam int ST_UNCORR = 61;
  localparam int GS_INPROG = 2;
  localparam int CAP_GCTL  = 8;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LOG_CE,
    ACT_LOG_UC,
    ACT_OVF_ONLY,
    ACT_RESET
  } act_e;

  function automatic logic switch_ok(word_t v);
    return (v == '0) || (v == '1);
  endfunction
endpackage

// File: rtl/mce_addr_map.sv
module mce_addr_map #(
  parameter int              ADDR_W    = 12,
  parameter int              NUM_BANKS = 10,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] CAP_ADDR  = 12'h010,
  parameter logic [ADDR_W-1:0] GST_ADDR  = 12'h011,
  parameter logic [ADDR_W-1:0] GCTL_ADDR = 12'h012,
  localparam int             IDX_W     = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_cap,
  output logic              hit_gst,
  output logic              hit_gctl,
  output logic              hit_bank,
  output logic [IDX_W-1:0]  bank_idx,
  output logic [1:0]        reg_sel
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_BANKS);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset   = addr - BANK_BASE;
    hit_cap  = (addr == CAP_ADDR);
    hit_gst  = (addr == GST_ADDR);
    hit_gctl = (addr == GCTL_ADDR);
    hit_bank = (addr >= BANK_BASE) && (offset < SPAN);
    bank_idx = offset[ADDR_W-1:2];
    reg_sel  = offset[1:0];
  end
endmodule

// File: rtl/mce_inject_eval.sv
module mce_inject_eval
  import mce_pkg::*;
#(
  parameter int   NUM_BANKS    = 10,
  parameter int   BANK_W       = 8,
  parameter logic GCTL_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_valid,
  input  logic [BANK_W-1:0] inj_bank,
  input  word_t             inj_status,
  input  word_t             gstat,
  input  word_t             gctl,
  input  word_t             cur_ctl,
  input  word_t             cur_st,
  input  logic              os_en,
  output act_e              act,
  output word_t             new_st
);
  localparam word_t OVF_BIT = word_t'(1) << ST_OVER;
  logic  in_rng;
  word_t ovf;

  always_comb begin
    in_rng = (inj_bank < BANK_W'(NUM_BANKS));
    ovf    = cur_st[ST_VALID] ? OVF_BIT : '0;
    act    = ACT_NONE;
    new_st = cur_st;
    if (inj_valid && in_rng && inj_status[ST_VALID]) begin
      if (inj_status[ST_UNCORR]) begin
        if ((GCTL_PRESENT && (gctl != '1)) || (cur_ctl != '1)) begin
          act = ACT_NONE;
        end else if (gstat[GS_INPROG] || !os_en) begin
          act = ACT_RESET;
        end else begin
          act    = ACT_LOG_UC;
          new_st = inj_status | ovf;
        end
      end else if (!cur_st[ST_VALID] || !cur_st[ST_UNCORR]) begin
        act    = ACT_LOG_CE;
        new_st = inj_status | ovf;
      end else begin
        act    = ACT_OVF_ONLY;
        new_st = cur_st | OVF_BIT;
      end
    end
  end

  // R5: out-of-range bank never leads to an action
  p_drop_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && (inj_bank >= BANK_W'(NUM_BANKS))) |-> (act == ACT_NONE));

  // R9: a corrected event never asks for exception or reset
  p_ce_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_status[ST_UNCORR]) |-> (act != ACT_LOG_UC && act != ACT_RESET));

  // R10: folding keeps the uncorrected record valid and marks overflow
  p_fold_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_OVF_ONLY) |-> (new_st[ST_VALID] && new_st[ST_UNCORR] && new_st[ST_OVER]));
endmodule

// File: rtl/mce_bank_ctrl.sv
module mce_bank_ctrl
  import mce_pkg::*;
#(
  parameter int   NUM_BANKS    = 10,
  parameter int   ADDR_W       = 12,
  parameter int   BANK_W       = 8,
  parameter logic GCTL_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_mce_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              inj_valid,
  input  logic [BANK_W-1:0] inj_bank,
  input  logic [63:0]       inj_status,
  input  logic [63:0]       inj_gstatus,
  input  logic [63:0]       inj_addr,
  input  logic [63:0]       inj_misc,
  output logic              mce_req,
  output logic              reset_req
);
  localparam int IDX_W = ADDR_W - 2;

  word_t bank_ctl_q [NUM_BANKS];
  word_t bank_st_q  [NUM_BANKS];
  word_t bank_ad_q  [NUM_BANKS];
  word_t bank_mi_q  [NUM_BANKS];
  word_t gst_q, gctl_q, gst_d, gctl_d, cap_w;
  logic  gst_en, gctl_en, mce_q, rst_q;

  logic             dec_cap, dec_gst, dec_gctl, dec_bank;
  logic [IDX_W-1:0] dec_idx;
  logic [1:0]       dec_reg;

  mce_addr_map #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_map (
    .addr(reg_addr), .hit_cap(dec_cap), .hit_gst(dec_gst), .hit_gctl(dec_gctl),
    .hit_bank(dec_bank), .bank_idx(dec_idx), .reg_sel(dec_reg)
  );

  word_t cur_ctl, cur_st, new_st;
  act_e  act;

  always_comb begin
    cur_ctl = '0;
    cur_st  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (inj_bank == BANK_W'(b)) begin
        cur_ctl = bank_ctl_q[b];
        cur_st  = bank_st_q[b];
      end
    end
  end

  mce_inject_eval #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .GCTL_PRESENT(GCTL_PRESENT)) u_eval (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_bank(inj_bank),
    .inj_status(inj_status), .gstat(gst_q), .gctl(gctl_q), .cur_ctl(cur_ctl),
    .cur_st(cur_st), .os_en(os_mce_en), .act(act), .new_st(new_st)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic  inj_hit, log_hit, wr_hit, ctl_en, st_en, ad_en, mi_en;
    word_t st_d, ad_d, mi_d;

    always_comb begin
      inj_hit = inj_valid && (inj_bank == BANK_W'(b));
      log_hit = inj_hit && ((act == ACT_LOG_CE) || (act == ACT_LOG_UC));
      wr_hit  = reg_we && dec_bank && (dec_idx == IDX_W'(b)) && !inj_hit;
      ctl_en  = wr_hit && (dec_reg == 2'd0) && switch_ok(reg_wdata);
      st_en   = log_hit || (inj_hit && (act == ACT_OVF_ONLY)) || (wr_hit && (dec_reg == 2'd1));
      st_d    = inj_hit ? new_st : reg_wdata;
      ad_en   = log_hit || (wr_hit && (dec_reg == 2'd2));
      ad_d    = log_hit ? inj_addr : reg_wdata;
      mi_en   = log_hit || (wr_hit && (dec_reg == 2'd3));
      mi_d    = log_hit ? inj_misc : reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_ctl_q[b] <= '1;
        bank_st_q[b]  <= '0;
        bank_ad_q[b]  <= '0;
        bank_mi_q[b]  <= '0;
      end else begin
        if (ctl_en) bank_ctl_q[b] <= reg_wdata;
        if (st_en)  bank_st_q[b]  <= st_d;
        if (ad_en)  bank_ad_q[b]  <= ad_d;
        if (mi_en)  bank_mi_q[b]  <= mi_d;
      end
    end

    // R3: a bank control word only ever holds one of the two switch values
    p_bank_ctl_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_ctl_q[b] == '0) || (bank_ctl_q[b] == '1));
  end

  always_comb begin
    gst_en  = (act == ACT_LOG_UC) || (reg_we && dec_gst);
    gst_d   = (act == ACT_LOG_UC) ? inj_gstatus : reg_wdata;
    gctl_en = reg_we && dec_gctl && GCTL_PRESENT && switch_ok(reg_wdata);
    gctl_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gst_q  <= '0;
      gctl_q <= '1;
      mce_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (gst_en)  gst_q  <= gst_d;
      if (gctl_en) gctl_q <= gctl_d;
      mce_q <= (act == ACT_LOG_UC);
      rst_q <= (act == ACT_RESET);
    end
  end

  always_comb begin
    cap_w           = '0;
    cap_w[7:0]      = 8'(NUM_BANKS);
    cap_w[CAP_GCTL] = GCTL_PRESENT;
    reg_rdata       = '0;
    if (dec_cap)  reg_rdata = cap_w;
    if (dec_gst)  reg_rdata = gst_q;
    if (dec_gctl) reg_rdata = GCTL_PRESENT ? gctl_q : '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec_bank && (dec_idx == IDX_W'(b))) begin
        case (dec_reg)
          2'd0:    reg_rdata = bank_ctl_q[b];
          2'd1:    reg_rdata = bank_st_q[b];
          2'd2:    reg_rdata = bank_ad_q[b];
          default: reg_rdata = bank_mi_q[b];
        endcase
      end
    end
  end

  assign mce_req   = mce_q;
  assign reset_req = rst_q;

  // R12: exception and reset requests are mutually exclusive
  p_one_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mce_req && reset_req));

  // R8: an exception request follows a strobed uncorrected event with the OS enable high
  p_mce_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mce_req |-> $past(inj_valid && inj_status[ST_UNCORR] && os_mce_en));

  // R7: a reset request follows a strobed uncorrected event
  p_rst_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(inj_valid && inj_status[ST_UNCORR]));

  // R3: global control holds only a switch value
  p_gctl_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gctl_q == '0) || (gctl_q == '1));
endmodule

// File: tb/mce_bank_ctrl_test.sv
module mce_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        os_mce_en;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [63:0] reg_wdata, reg_rdata;
  logic        inj_valid;
  logic [7:0]  inj_bank;
  logic [63:0] inj_status, inj_gstatus, inj_addr, inj_misc;
  logic        mce_req, reset_req;

  always #10 clk = ~clk;

  mce_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .os_mce_en(os_mce_en), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .inj_valid(inj_valid), .inj_bank(inj_bank), .inj_status(inj_status),
    .inj_gstatus(inj_gstatus), .inj_addr(inj_addr), .inj_misc(inj_misc),
    .mce_req(mce_req), .reset_req(reset_req)
  );

  localparam logic [63:0] VB   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OB   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] UB   = 64'h2000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;
  localparam logic [11:0] A_CAP = 12'h010, A_GST = 12'h011, A_GCTL = 12'h012;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  bit          kq[$];
  logic [63:0] eq[$];
  string       tq[$];

  function automatic logic [11:0] ba(int b, int r);
    return 12'h400 + 12'(4 * b + r);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (eq.size() > 0) begin
        bit k;
        logic [63:0] e, got;
        string t;
        k = kq.pop_front();
        e = eq.pop_front();
        t = tq.pop_front();
        got = k ? {62'd0, reset_req, mce_req} : reg_rdata;
        checks++;
        if (got !== e) begin
          failures++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, reg_addr, got, e);
        end
      end
    end
  end

  task automatic chk(input logic [11:0] a, input logic [63:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    reg_we   = 1'b0;
    kq.push_back(1'b0); eq.push_back(e); tq.push_back(t);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic inject(input int b, input logic [63:0] st, input logic [63:0] gs,
                        input logic [63:0] ad, input logic [63:0] mi,
                        input logic exp_mce, input logic exp_rst, input string t);
    @(negedge clk);
    inj_valid = 1'b1; inj_bank = 8'(b); inj_status = st;
    inj_gstatus = gs; inj_addr = ad; inj_misc = mi;
    @(negedge clk);
    inj_valid = 1'b0;
    kq.push_back(1'b1); eq.push_back({62'd0, exp_rst, exp_mce}); tq.push_back(t);
    @(negedge clk);
    kq.push_back(1'b1); eq.push_back(64'd0); tq.push_back({t, " R12 pulse end"});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; os_mce_en = 1'b1; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    inj_valid = 1'b0; inj_bank = '0; inj_status = '0; inj_gstatus = '0;
    inj_addr = '0; inj_misc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(A_CAP, 64'h10A, "R1 cap");
    chk(ba(0, 0), ONES, "R1 bank0 ctl");
    chk(ba(9, 0), ONES, "R1 bank9 ctl");
    chk(ba(3, 1), 64'd0, "R1 bank3 status");
    chk(ba(7, 3), 64'd0, "R1 bank7 misc");
    chk(A_GCTL, ONES, "R1 gctl");
    chk(A_GST, 64'd0, "R1 gstatus");
    @(negedge clk);
    kq.push_back(1'b1); eq.push_back(64'd0); tq.push_back("R1 no requests");

    // R3 control write filter
    wr(ba(2, 0), 64'h1234);
    chk(ba(2, 0), ONES, "R3 bank ctl odd value ignored");
    wr(ba(2, 0), 64'd0);
    chk(ba(2, 0), 64'd0, "R3 bank ctl zero accepted");
    wr(A_GCTL, 64'h5);
    chk(A_GCTL, ONES, "R3 gctl odd value ignored");

    // R4 free registers
    wr(ba(2, 2), 64'hDEAD_BEEF_0123_4567);
    chk(ba(2, 2), 64'hDEAD_BEEF_0123_4567, "R4 bank addr");
    wr(ba(6, 3), 64'h0F0F_0000_1111_2222);
    chk(ba(6, 3), 64'h0F0F_0000_1111_2222, "R4 bank misc");
    wr(A_GST, 64'h55);
    chk(A_GST, 64'h55, "R4 gstatus");
    wr(A_GST, 64'h0);
    chk(A_GST, 64'h0, "R4 gstatus cleared");

    // R2 unmapped
    chk(12'h428, 64'd0, "R2 past last bank");
    wr(12'h428, 64'h99);
    chk(12'h428, 64'd0, "R2 write to hole");
    chk(12'h3FF, 64'd0, "R2 below bank base");
    chk(ba(9, 3), 64'd0, "R2 last bank misc untouched");

    // R5 ignored injections
    inject(10, VB | UB | 64'h1, 64'h0, 64'hA0, 64'hB0, 1'b0, 1'b0, "R5 bank out of range");
    inject(1, 64'h11, 64'h0, 64'hA0, 64'hB0, 1'b0, 1'b0, "R5 valid clear");
    chk(ba(1, 1), 64'd0, "R5 bank1 status untouched");
    chk(ba(1, 2), 64'd0, "R5 bank1 addr untouched");

    // R9 corrected logging
    inject(1, VB | 64'h11, 64'h0, 64'hA1, 64'hB1, 1'b0, 1'b0, "R9 first corrected");
    chk(ba(1, 1), VB | 64'h11, "R9 status first");
    chk(ba(1, 2), 64'hA1, "R9 addr first");
    inject(1, VB | 64'h22, 64'h0, 64'hA2, 64'hB2, 1'b0, 1'b0, "R9 second corrected");
    chk(ba(1, 1), VB | OB | 64'h22, "R9 status overflow");
    chk(ba(1, 3), 64'hB2, "R9 misc replaced");

    // R6 drops (bank2 ctl is zero)
    inject(2, VB | UB | 64'h1, 64'h0, 64'hA5, 64'hB5, 1'b0, 1'b0, "R6 bank ctl off");
    chk(ba(2, 1), 64'd0, "R6 bank2 status untouched");
    wr(ba(2, 0), ONES);
    wr(A_GCTL, 64'd0);
    chk(A_GCTL, 64'd0, "R3 gctl zero accepted");
    inject(2, VB | UB | 64'h1, 64'h0, 64'hA5, 64'hB5, 1'b0, 1'b0, "R6 gctl off");
    chk(ba(2, 1), 64'd0, "R6 bank2 status still empty");
    wr(A_GCTL, ONES);

    // R7 enable low
    @(negedge clk); os_mce_en = 1'b0;
    inject(3, VB | UB | 64'h30, 64'h4, 64'hA3, 64'hB3, 1'b0, 1'b1, "R7 os enable low");
    chk(ba(3, 1), 64'd0, "R7 nothing logged");
    chk(A_GST, 64'd0, "R7 gstatus untouched");
    @(negedge clk); os_mce_en = 1'b1;

    // R8 accepted uncorrected
    inject(3, VB | UB | 64'h33, 64'h4, 64'hA3, 64'hB3, 1'b1, 1'b0, "R8 uncorrected accepted");
    chk(ba(3, 1), VB | UB | 64'h33, "R8 status");
    chk(ba(3, 2), 64'hA3, "R8 addr");
    chk(ba(3, 3), 64'hB3, "R8 misc");
    chk(A_GST, 64'h4, "R8 gstatus");

    // R7 in-progress escalation
    inject(4, VB | UB | 64'h40, 64'h4, 64'hA4, 64'hB4, 1'b0, 1'b1, "R7 in progress");
    chk(ba(4, 1), 64'd0, "R7 bank4 untouched");
    wr(A_GST, 64'h0);

    // R10 corrected onto uncorrected
    inject(3, VB | 64'h44, 64'h0, 64'hA9, 64'hB9, 1'b0, 1'b0, "R10 fold");
    chk(ba(3, 1), VB | OB | UB | 64'h33, "R10 status overflow only");
    chk(ba(3, 2), 64'hA3, "R10 addr kept");

    // R8 overflow on valid bank
    inject(3, VB | UB | 64'h55, 64'h4, 64'hAA, 64'hBA, 1'b1, 1'b0, "R8 uncorrected over valid");
    chk(ba(3, 1), VB | OB | UB | 64'h55, "R8 status with overflow");
    chk(ba(3, 2), 64'hAA, "R8 addr replaced");

    // R11 injection vs write
    @(negedge clk);
    inj_valid = 1'b1; inj_bank = 8'd5; inj_status = VB | 64'h66;
    inj_addr = 64'hA6; inj_misc = 64'hB6; inj_gstatus = 64'h0;
    reg_addr = ba(5, 1); reg_wdata = 64'h1111; reg_we = 1'b1;
    @(negedge clk);
    inj_valid = 1'b0; reg_we = 1'b0;
    chk(ba(5, 1), VB | 64'h66, "R11 same bank write discarded");
    @(negedge clk);
    inj_valid = 1'b1; inj_bank = 8'd5; inj_status = VB | 64'h67;
    reg_addr = ba(6, 2); reg_wdata = 64'h77; reg_we = 1'b1;
    @(negedge clk);
    inj_valid = 1'b0; reg_we = 1'b0;
    chk(ba(6, 2), 64'h77, "R11 other bank write kept");
    chk(ba(5, 1), VB | OB | 64'h67, "R11 injection applied");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule